// File: doc/BRIEF.md
# Address-Space Network Table Walker

This block turns an (address-space ID, network ID) pair into the memory address of that network's configuration record. The operating system builds a two-level table in memory. A supervisor register holds the table's base address, and a second one holds how many address spaces are valid. IDs are handed out sequentially from zero, so each ID is used directly as an array index.

The first level has one entry per address space. Each entry is three pointer-sized words: a pointer to the space's network array, the number of networks the space owns, and a pointer to the space's I/O queue. The second level is the network array itself, where each word points to one configuration.

A client presents a request. The walker checks the address-space ID against the valid count, then reads the entry through a simple read port. It checks the network ID against the entry's count, reads the configuration pointer, and answers with both pointers or with a fault code. A space can only reach networks listed in its own array, which keeps processes apart. Only one request is in flight at a time.

Top module: `asnet_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A request whose address-space ID is greater than or equal to `cfg_num_as` is answered with `rsp_fault` = 1. The response appears in the cycle after acceptance, and no memory read is issued.
- R3: For an in-range address-space ID A, the entry words are read in this order: `cfg_tbl_base + A*3*WORD_BYTES`, then plus `WORD_BYTES` (network count), then plus `2*WORD_BYTES` (queue pointer). The first of these three words is the array pointer.
- R4: A network ID greater than or equal to the count word is answered with `rsp_fault` = 2, after exactly the three entry reads and no further read.
- R5: For a network ID N within bounds, a fourth read is issued at `array pointer + N*WORD_BYTES`. The response then has `rsp_fault` = 0, `rsp_cfg_ptr` equal to that read's data, and `rsp_queue_ptr` equal to the third entry word.
- R6: `req_ready` is 0 from the cycle after a request is accepted until the response handshake completes, and 1 in the cycle after that handshake.
- R7: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged. The walker waits any number of cycles.
- R8: At most one read is outstanding. No new read request is raised until the data of the previous one has returned, however late it arrives.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and all its fields stay unchanged.
- R10: A fault response (code 1 or 2) carries zero in both `rsp_cfg_ptr` and `rsp_queue_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_tbl_base | input | AW | Supervisor: table base address |
| cfg_num_as | input | IDW | Supervisor: number of valid address spaces |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_asid | input | IDW | Address-space ID |
| req_nnid | input | IDW | Network ID |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Client accepts the response |
| rsp_fault | output | 2 | 0 ok, 1 bad address space, 2 bad network |
| rsp_cfg_ptr | output | AW | Configuration address |
| rsp_queue_ptr | output | AW | I/O queue address |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | AW | Byte address to read |
| mem_rsp_valid | input | 1 | Read data valid, in order |
| mem_rsp_data | input | AW | Read data word |

## Verification
A wrong step counter or a wrong latched ID shows up at once on `mem_req_addr`. Every read address is therefore compared against the address the requirements predict, in issue order. A wrong count word or a wrong bound compare shows within the same transaction, as a fault code that does not match or a read count that does not match. Stale pointer registers show up as nonzero pointers on a fault response. A state machine stuck outside its idle state leaves `req_ready` low, and the next request exposes it within one cycle.

// File: rtl/asnet_pkg.sv
package asnet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WT   = 2'd2,
        ST_RESP = 2'd3
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ASID = 2'd1,
        FLT_NNID = 2'd2
    } walk_fault_e;

    // read steps of one walk
    localparam logic [1:0] STEP_ARR = 2'd0;
    localparam logic [1:0] STEP_CNT = 2'd1;
    localparam logic [1:0] STEP_QUE = 2'd2;
    localparam logic [1:0] STEP_CFG = 2'd3;

endpackage

// File: rtl/asnet_bound_chk.sv
module asnet_bound_chk #(
    parameter int W = 8
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] limit,
    output logic         in_range
);
    assign in_range = (idx < limit);
endmodule

// File: rtl/asnet_addr_gen.sv
module asnet_addr_gen
    import asnet_pkg::*;
#(
    parameter int AW         = 32,
    parameter int IDW        = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0]  tbl_base,
    input  logic [IDW-1:0] asid,
    input  logic [IDW-1:0] nnid,
    input  logic [AW-1:0]  arr_ptr,
    input  logic [1:0]     step,
    output logic [AW-1:0]  addr
);
    localparam int ENTRY_BYTES = 3 * WORD_BYTES;

    logic [AW-1:0] entry_base;
    logic [AW-1:0] entry_word;
    logic [AW-1:0] net_word;

    always_comb begin
        entry_base = tbl_base + AW'(AW'(asid) * AW'(ENTRY_BYTES));
        entry_word = entry_base + AW'(AW'(step) * AW'(WORD_BYTES));
        net_word   = arr_ptr + AW'(AW'(nnid) * AW'(WORD_BYTES));
        addr       = (step == STEP_CFG) ? net_word : entry_word;
    end
endmodule

// File: rtl/asnet_walker.sv
module asnet_walker
    import asnet_pkg::*;
#(
    parameter int AW         = 32,
    parameter int IDW        = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cfg_tbl_base,
    input  logic [IDW-1:0] cfg_num_as,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [IDW-1:0] req_asid,
    input  logic [IDW-1:0] req_nnid,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic [1:0]     rsp_fault,
    output logic [AW-1:0]  rsp_cfg_ptr,
    output logic [AW-1:0]  rsp_queue_ptr,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [AW-1:0]  mem_rsp_data
);
    typedef struct packed {
        walk_st_e     st;
        logic [1:0]   step;
        logic [IDW-1:0] asid;
        logic [IDW-1:0] nnid;
        logic [AW-1:0]  arr_ptr;
        logic [AW-1:0]  cnt;
        logic [AW-1:0]  q_ptr;
        logic [AW-1:0]  cfg_ptr;
        walk_fault_e  fault;
    } walk_s;

    walk_s s_d, s_q;

    logic asid_ok;
    logic nnid_ok;
    logic [AW-1:0] rd_addr;

    asnet_bound_chk #(.W(IDW)) u_asid_chk (
        .idx      (req_asid),
        .limit    (cfg_num_as),
        .in_range (asid_ok)
    );

    asnet_bound_chk #(.W(AW)) u_nnid_chk (
        .idx      (AW'(s_q.nnid)),
        .limit    (s_q.cnt),
        .in_range (nnid_ok)
    );

    asnet_addr_gen #(
        .AW         (AW),
        .IDW        (IDW),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .tbl_base (cfg_tbl_base),
        .asid     (s_q.asid),
        .nnid     (s_q.nnid),
        .arr_ptr  (s_q.arr_ptr),
        .step     (s_q.step),
        .addr     (rd_addr)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.asid    = req_asid;
                    s_d.nnid    = req_nnid;
                    s_d.step    = STEP_ARR;
                    s_d.arr_ptr = '0;
                    s_d.cnt     = '0;
                    s_d.q_ptr   = '0;
                    s_d.cfg_ptr = '0;
                    if (asid_ok) begin
                        s_d.fault = FLT_NONE;
                        s_d.st    = ST_RD;
                    end else begin
                        s_d.fault = FLT_ASID;
                        s_d.st    = ST_RESP;
                    end
                end
            end
            ST_RD: begin
                if (mem_req_ready) begin
                    s_d.st = ST_WT;
                end
            end
            ST_WT: begin
                if (mem_rsp_valid) begin
                    unique case (s_q.step)
                        STEP_ARR: begin
                            s_d.arr_ptr = mem_rsp_data;
                            s_d.step    = STEP_CNT;
                            s_d.st      = ST_RD;
                        end
                        STEP_CNT: begin
                            s_d.cnt  = mem_rsp_data;
                            s_d.step = STEP_QUE;
                            s_d.st   = ST_RD;
                        end
                        STEP_QUE: begin
                            if (nnid_ok) begin
                                s_d.q_ptr = mem_rsp_data;
                                s_d.step  = STEP_CFG;
                                s_d.st    = ST_RD;
                            end else begin
                                s_d.fault = FLT_NNID;
                                s_d.st    = ST_RESP;
                            end
                        end
                        default: begin
                            s_d.cfg_ptr = mem_rsp_data;
                            s_d.st      = ST_RESP;
                        end
                    endcase
                end
            end
            default: begin
                if (rsp_ready) begin
                    s_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, step: STEP_ARR, asid: '0, nnid: '0,
                     arr_ptr: '0, cnt: '0, q_ptr: '0, cfg_ptr: '0,
                     fault: FLT_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready     = (s_q.st == ST_IDLE);
    assign mem_req_valid = (s_q.st == ST_RD);
    assign mem_req_addr  = rd_addr;
    assign rsp_valid     = (s_q.st == ST_RESP);
    assign rsp_fault     = s_q.fault;
    assign rsp_cfg_ptr   = s_q.cfg_ptr;
    assign rsp_queue_ptr = s_q.q_ptr;

endmodule

// File: rtl/asnet_walker_chk.sv
module asnet_walker_chk #(
    parameter int AW  = 32,
    parameter int IDW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [IDW-1:0] cfg_num_as,
    input logic           req_valid,
    input logic           req_ready,
    input logic [IDW-1:0] req_asid,
    input logic           rsp_valid,
    input logic           rsp_ready,
    input logic [1:0]     rsp_fault,
    input logic [AW-1:0]  rsp_cfg_ptr,
    input logic [AW-1:0]  rsp_queue_ptr,
    input logic           mem_req_valid,
    input logic           mem_req_ready,
    input logic [AW-1:0]  mem_req_addr,
    input logic           mem_rsp_valid
);
    logic outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            outst_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            outst_q <= 1'b0;
        end
    end

    AST_ASID_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_asid >= cfg_num_as))
        |=> (rsp_valid && rsp_fault == 2'd1 && !mem_req_valid)); // R2

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R6

    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R6

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr))); // R7

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outst_q); // R8

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready)
        |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_cfg_ptr)
             && $stable(rsp_queue_ptr))); // R9

    AST_FAULT_ZERO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0)
        |-> (rsp_cfg_ptr == '0 && rsp_queue_ptr == '0)); // R10

endmodule

bind asnet_walker asnet_walker_chk #(.AW(AW), .IDW(IDW)) u_chk (.*);

// File: tb/asnet_walker_bench.sv
`timescale 1ns/1ps
module asnet_walker_bench;
    localparam int AW  = 32;
    localparam int IDW = 8;
    localparam int WB  = 4;
    localparam int NAS = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  cfg_tbl_base = 32'h0000_1000;
    logic [IDW-1:0] cfg_num_as = IDW'(NAS);
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [IDW-1:0] req_asid = '0;
    logic [IDW-1:0] req_nnid = '0;
    logic           rsp_valid;
    logic           rsp_ready = 1'b0;
    logic [1:0]     rsp_fault;
    logic [AW-1:0]  rsp_cfg_ptr;
    logic [AW-1:0]  rsp_queue_ptr;
    logic           mem_req_valid;
    logic           mem_req_ready = 1'b0;
    logic [AW-1:0]  mem_req_addr;
    logic           mem_rsp_valid = 1'b0;
    logic [AW-1:0]  mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    logic [AW-1:0] log_addr [0:7];
    int log_n = 0;

    always #2.5 clk = ~clk;

    asnet_walker #(.AW(AW), .IDW(IDW), .WORD_BYTES(WB)) u_asnet_walker (.*);

    function automatic logic [AW-1:0] arrp(int a); return 32'h4000 + a * 32'h100; endfunction
    function automatic logic [AW-1:0] cntw(int a); return a % 5; endfunction
    function automatic logic [AW-1:0] qp(int a);   return 32'h8000 + a * 16; endfunction
    function automatic logic [AW-1:0] netp(int a, int j);
        return 32'hC000_0000 | (a << 8) | j;
    endfunction

    function automatic logic [AW-1:0] memval(logic [AW-1:0] addr);
        int off, a, w;
        if (addr >= cfg_tbl_base && addr < cfg_tbl_base + NAS * 12) begin
            off = int'(addr - cfg_tbl_base);
            a = off / 12;
            w = (off % 12) / 4;
            if (w == 0) return arrp(a);
            if (w == 1) return cntw(a);
            return qp(a);
        end
        if (addr >= 32'h4000 && addr < 32'h5000) begin
            return netp(int'((addr - 32'h4000) >> 8), int'((addr & 32'hff) >> 2));
        end
        return 32'hDEAD_BEEF;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: random ready, random latency, one read at a time
    initial begin
        logic r_prev, v_prev, pend;
        logic [AW-1:0] a_prev, pend_addr;
        int lat;
        r_prev = 0; v_prev = 0; pend = 0; a_prev = '0; pend_addr = '0; lat = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (r_prev && v_prev && rst_n) begin
                if (log_n < 8) log_addr[log_n] = a_prev;
                log_n++;
                pend = 1;
                pend_addr = a_prev;
                lat = $urandom % 4;
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = memval(pend_addr);
                    pend = 0;
                end else begin
                    lat--;
                end
            end
            mem_req_ready = !pend && !mem_rsp_valid && ($urandom % 3 != 0);
            v_prev = mem_req_valid;
            a_prev = mem_req_addr;
            r_prev = mem_req_ready;
        end
    end

    task automatic run_txn(input int asid, input int nnid, input bit slow);
        int ef, nreads, w;
        logic [AW-1:0] ecfg, eq, ent;
        logic [1:0] f0;
        logic [AW-1:0] c0, q0;
        ent = cfg_tbl_base + asid * 12;
        if (asid >= int'(cfg_num_as)) begin ef = 1; nreads = 0; ecfg = 0; eq = 0; end
        else if (nnid >= int'(cntw(asid))) begin ef = 2; nreads = 3; ecfg = 0; eq = 0; end
        else begin ef = 0; nreads = 4; ecfg = netp(asid, nnid); eq = qp(asid); end
        log_n = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R6", "ready before request", AW'(req_ready), 1);
        req_valid = 1'b1;
        req_asid = IDW'(asid);
        req_nnid = IDW'(nnid);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R6", "ready after accept", AW'(req_ready), 0);
        if (ef == 1)
            chk(rsp_valid == 1'b1, "R2", "response next cycle", AW'(rsp_valid), 1);
        w = 0;
        while (!rsp_valid && w < 500) begin
            @(negedge clk);
            w++;
        end
        chk(rsp_valid == 1'b1, "R8", "response arrives", AW'(rsp_valid), 1);
        chk(int'(rsp_fault) == ef, ef == 1 ? "R2" : (ef == 2 ? "R4" : "R5"),
            "fault code", AW'(rsp_fault), AW'(ef));
        chk(rsp_cfg_ptr == ecfg, ef != 0 ? "R10" : "R5", "cfg ptr", rsp_cfg_ptr, ecfg);
        chk(rsp_queue_ptr == eq, ef != 0 ? "R10" : "R5", "queue ptr", rsp_queue_ptr, eq);
        chk(log_n == nreads, ef == 1 ? "R2" : (ef == 2 ? "R4" : "R5"),
            "read count", AW'(log_n), AW'(nreads));
        if (nreads >= 3 && log_n >= 3) begin
            for (int k = 0; k < 3; k++)
                chk(log_addr[k] == ent + AW'(k * WB), "R3", "entry read addr",
                    log_addr[k], ent + AW'(k * WB));
        end
        if (nreads == 4 && log_n >= 4)
            chk(log_addr[3] == arrp(asid) + AW'(nnid * WB), "R5", "config read addr",
                log_addr[3], arrp(asid) + AW'(nnid * WB));
        if (slow) begin
            f0 = rsp_fault; c0 = rsp_cfg_ptr; q0 = rsp_queue_ptr;
            repeat (2) @(negedge clk);
            chk(rsp_valid && rsp_fault == f0 && rsp_cfg_ptr == c0 && rsp_queue_ptr == q0,
                "R9", "response held", rsp_cfg_ptr, c0);
            chk(req_ready == 1'b0, "R6", "ready while response pending", AW'(req_ready), 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid == 1'b0, "R9", "response dropped after handshake", AW'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R6", "ready after handshake", AW'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset req_ready", AW'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", AW'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", AW'(mem_req_valid), 0);
        rst_n = 1'b1;
        // directed corners
        run_txn(0, 0, 0);   // space with no networks: R4
        run_txn(3, 2, 1);   // last valid network, held response: R5 R9
        run_txn(3, 3, 0);   // network count boundary: R4
        run_txn(6, 0, 0);   // last valid space: R5
        run_txn(7, 0, 1);   // space count boundary: R2
        run_txn(200, 1, 0); // far out of range: R2
        cfg_num_as = '0;
        run_txn(0, 0, 0);   // no valid spaces: R2
        cfg_num_as = IDW'(NAS);
        cfg_tbl_base = 32'h0000_2000;
        run_txn(4, 1, 0);   // moved table: R3 R5
        for (int i = 0; i < 80; i++)
            run_txn($urandom % 10, $urandom % 6, ($urandom % 4) == 0);
        cfg_tbl_base = 32'h0000_1000;
        for (int i = 0; i < 20; i++)
            run_txn($urandom % 8, $urandom % 5, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule